// File: doc/BRIEF.md
# Overflow-Event Up-Counter Timer

This block holds two identical timer channels behind a small register bus. Each channel has a 32-bit counter that counts upward. When the counter is at its all-ones value and one more tick arrives, it overflows: it loads its initial value again, keeps running and sets a sticky pending flag. Software schedules an event N+1 ticks away by holding the counter, writing the all-ones value minus N as the initial value, and then starting it. Each channel has its own clock prescaler, so ticks can be slower than the input clock.

The two channels are identical. In normal use one channel makes timed events and raises the interrupt, and the other runs freely as a time base that software reads. The bus uses single-cycle read and write strobes. Read data is registered and appears on the cycle after the read strobe. A single level interrupt combines both channels.

Top module: `wrap_timer`

## Requirements
- R1: After reset every register of both channels reads as zero, `bus_rdata` is zero and `irq_o` is low.
- R2: The address is a byte offset. Bits [5:0] select the register in a channel and bit 6 selects the channel, so the second channel starts at 0x40. The per-channel offsets are: pending status 0x00, live count 0x04, control 0x10, configuration 0x20, prescale divider 0x24 and initial value 0x28. An offset that maps to no register reads as zero. Read data appears in the cycle after the read strobe and stays unchanged while no read is issued.
- R3: Control bit 0 (hold) forces the counter to the initial value and keeps it stopped. The counter runs only when control bit 1 (start) is 1, hold is 0 and configuration bit 0 (enable) is 1. A control write that sets hold or start loads the initial value into the counter at once.
- R4: A running counter advances by one on every prescaler tick. With a divider value of D, a tick comes once every D+1 input clocks, so a divider of 0 gives one tick per clock. The prescaler starts its count again whenever the counter is not running.
- R5: When a tick arrives while the count is all ones, the counter reloads the initial value and keeps counting, and status bit 0 (pending) is set. So an initial value of all-ones minus N sets pending N+1 ticks after start.
- R6: Writing 1 to status bit 0 clears pending, and writing 0 there has no effect. An overflow in the same cycle as a clear wins, so pending stays set.
- R7: `irq_o` is high when any channel has pending, enable (configuration bit 0) and interrupt enable (configuration bit 1) all set.
- R8: While enable is 0 the counter keeps its value and does not advance. Setting enable again resumes counting from that value, with no reload.
- R9: The live count register is read-only: a write to it does not change the count.
- R10: The two channels are independent: registers, counting and interrupts in one channel do not affect the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 7 | Byte address: bit 6 selects the channel, bits [5:0] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt, OR of the enabled pending flags |

## Verification
A counter that loads, steps or reloads wrongly shows up on the very next read of the live count register, and back-to-back reads show the step rate directly. A pending flag that is set or cleared in the wrong cycle shows on `irq_o` one clock after the edge where it happens. The bench therefore places a status clear exactly on an overflow edge and checks the interrupt on the following cycle. A prescaler that is off by one shifts the cycle in which each count value first appears, so reads taken every cycle with a non-zero divider expose it within D+2 clocks.

// File: rtl/wrap_timer_pkg.sv
package wrap_timer_pkg;

    // register byte offsets inside one channel window
    localparam int          CH_SPAN_BITS = 6;
    localparam logic [5:0]  OFF_STAT     = 6'h00;
    localparam logic [5:0]  OFF_VALUE    = 6'h04;
    localparam logic [5:0]  OFF_CTRL     = 6'h10;
    localparam logic [5:0]  OFF_CFG      = 6'h20;
    localparam logic [5:0]  OFF_DIV      = 6'h24;
    localparam logic [5:0]  OFF_INIT     = 6'h28;

    // field positions
    localparam int STAT_PEND_BIT  = 0;
    localparam int CTRL_HOLD_BIT  = 0;
    localparam int CTRL_START_BIT = 1;
    localparam int CFG_EN_BIT     = 0;
    localparam int CFG_IEN_BIT    = 1;

endpackage

// File: rtl/wrap_timer_prescale.sv
module wrap_timer_prescale #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] pcnt;
    } pre_state_t;

    pre_state_t q, d;

    // a divider lowered below the current phase fires at once
    assign tick = run && (q.pcnt >= div);

    always_comb begin
        d = q;
        if (!run || restart || tick) begin
            d.pcnt = '0;
        end else begin
            d.pcnt = q.pcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R4: with a non-zero divider two ticks are never adjacent
    a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (div != '0) && !restart) |=> (!tick || !$stable(div)))
        else $error("a_r4_tick_spacing");

endmodule

// File: rtl/wrap_timer_chan.sv
module wrap_timer_chan
    import wrap_timer_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [5:0]       off,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rd_word,
    output logic             irq
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] init;
        logic [DIV_W-1:0] div;
        logic             hold;
        logic             start;
        logic             en;
        logic             ien;
        logic             pending;
    } chan_state_t;

    chan_state_t q, d;

    logic wr_stat, wr_ctrl, wr_cfg, wr_div, wr_init;
    logic run, start_load, tick, wrap;

    assign wr_stat    = wr_en && (off == OFF_STAT);
    assign wr_ctrl    = wr_en && (off == OFF_CTRL);
    assign wr_cfg     = wr_en && (off == OFF_CFG);
    assign wr_div     = wr_en && (off == OFF_DIV);
    assign wr_init    = wr_en && (off == OFF_INIT);

    assign run        = q.en && q.start && !q.hold;
    assign start_load = wr_ctrl && (wdata[CTRL_HOLD_BIT] || wdata[CTRL_START_BIT]);
    assign wrap       = run && tick && (q.count == CNT_MAX);

    wrap_timer_prescale #(
        .DIV_W (DIV_W)
    ) u_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (start_load),
        .div     (q.div),
        .tick    (tick)
    );

    always_comb begin
        d = q;
        if (wr_cfg) begin
            d.en  = wdata[CFG_EN_BIT];
            d.ien = wdata[CFG_IEN_BIT];
        end
        if (wr_div) begin
            d.div = wdata[DIV_W-1:0];
        end
        if (wr_init) begin
            d.init = wdata;
        end
        if (wr_ctrl) begin
            d.hold  = wdata[CTRL_HOLD_BIT];
            d.start = wdata[CTRL_START_BIT];
        end
        // the live count register accepts no writes
        if (start_load || q.hold || wrap) begin
            d.count = q.init;
        end else if (run && tick) begin
            d.count = q.count + 1'b1;
        end
        // overflow outranks a clear in the same cycle
        if (wrap) begin
            d.pending = 1'b1;
        end else if (wr_stat && wdata[STAT_PEND_BIT]) begin
            d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rd_word = '0;
        unique case (off)
            OFF_STAT:  rd_word[STAT_PEND_BIT] = q.pending;
            OFF_VALUE: rd_word = q.count;
            OFF_CTRL: begin
                rd_word[CTRL_HOLD_BIT]  = q.hold;
                rd_word[CTRL_START_BIT] = q.start;
            end
            OFF_CFG: begin
                rd_word[CFG_EN_BIT]  = q.en;
                rd_word[CFG_IEN_BIT] = q.ien;
            end
            OFF_DIV:   rd_word = CNT_W'(q.div);
            OFF_INIT:  rd_word = q.init;
            default:   rd_word = '0;
        endcase
    end

    assign irq = q.pending && q.en && q.ien;

    // R3: a held counter sits at the initial value one cycle later
    a_r3_hold_pins_count: assert property (@(posedge clk) disable iff (!rst_n)
        q.hold |=> (q.count == $past(q.init)))
        else $error("a_r3_hold_pins_count");

    // R5: an overflow tick reloads and raises pending
    a_r5_wrap_reloads: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && (q.count == CNT_MAX)) |=> (q.pending && (q.count == $past(q.init))))
        else $error("a_r5_wrap_reloads");

    // R6: a clear with no coinciding overflow drops pending
    a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wdata[STAT_PEND_BIT] && !(run && tick && (q.count == CNT_MAX))) |=> !q.pending)
        else $error("a_r6_clear_drops");

    // R8: a disabled counter keeps its value
    a_r8_disabled_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.en && !q.hold && !wr_ctrl) |=> $stable(q.count))
        else $error("a_r8_disabled_frozen");

endmodule

// File: rtl/wrap_timer.sv
module wrap_timer
    import wrap_timer_pkg::*;
#(
    parameter  int NUM_CH  = 2,
    parameter  int CNT_W   = 32,
    parameter  int DIV_W   = 16,
    localparam int CH_BITS = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W  = CH_SPAN_BITS + CH_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq_o
);

    typedef struct packed {
        logic [CNT_W-1:0] rdata;
    } top_state_t;

    top_state_t q, d;

    logic [CH_BITS-1:0]      ch_idx;
    logic [CH_SPAN_BITS-1:0] ch_off;
    logic [CNT_W-1:0]        rd_word [NUM_CH];
    logic [NUM_CH-1:0]       irq_vec;

    assign ch_idx = bus_addr[ADDR_W-1:CH_SPAN_BITS];
    assign ch_off = bus_addr[CH_SPAN_BITS-1:0];

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_chan
        wrap_timer_chan #(
            .CNT_W (CNT_W),
            .DIV_W (DIV_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bus_wr && (ch_idx == CH_BITS'(gi))),
            .off     (ch_off),
            .wdata   (bus_wdata),
            .rd_word (rd_word[gi]),
            .irq     (irq_vec[gi])
        );
    end

    always_comb begin
        d = q;
        if (bus_rd) begin
            d.rdata = '0;
            for (int i = 0; i < NUM_CH; i++) begin
                if (ch_idx == CH_BITS'(i)) begin
                    d.rdata = rd_word[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign bus_rdata = q.rdata;
    assign irq_o     = |irq_vec;

    // R2: read data only moves after a read strobe
    a_r2_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata))
        else $error("a_r2_rdata_holds");

endmodule

// File: tb/wrap_timer_bench.sv
`timescale 1ns/1ps
module wrap_timer_bench;

    localparam logic [31:0] MAXV = 32'hFFFF_FFFF;
    localparam logic [6:0] C0_STAT = 7'h00, C0_VAL = 7'h04, C0_CTRL = 7'h10,
                           C0_CFG  = 7'h20, C0_DIV = 7'h24, C0_INIT = 7'h28;
    localparam logic [6:0] C1_VAL  = 7'h44, C1_CTRL = 7'h50, C1_CFG = 7'h60,
                           C1_INIT = 7'h68;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    always #2 clk = ~clk;

    wrap_timer u_wrap_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    typedef struct {
        logic [31:0] val;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t mon_e;
    int   n_chk  = 0;
    int   n_fail = 0;
    logic rd_seen = 1'b0;

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: all tasks start and end at a falling edge
    task automatic wr(input logic [6:0] a, input logic [31:0] v);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, input logic [31:0] e, input string tag);
        exp_t it;
        it.val = e; it.tag = tag;
        exp_q.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        check(irq_o === e, tag, {31'd0, irq_o}, {31'd0, e});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // monitor: pops one expected item per completed read
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 read with no expected item", bus_rdata, 32'h0);
            end else begin
                mon_e = exp_q.pop_front();
                check(bus_rdata === mon_e.val, mon_e.tag, bus_rdata, mon_e.val);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'h0, 32'h0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        chk_irq(1'b0, "R1 irq after reset");
        check(bus_rdata === 32'h0, "R1 rdata after reset", bus_rdata, 32'h0);
        rd(C0_VAL, 32'h0, "R1 ch0 count");
        rd(C0_CFG, 32'h0, "R1 ch0 config");
        rd(C1_INIT, 32'h0, "R1 ch1 init");
        rd(C0_STAT, 32'h0, "R1 ch0 status");

        // R2 map and R9 read-only count
        wr(C0_INIT, 32'h1234_5678);
        rd(C0_INIT, 32'h1234_5678, "R2 init readback");
        wr(C0_DIV, 32'h0000_0003);
        rd(C0_DIV, 32'h0000_0003, "R2 divider readback");
        wr(C0_VAL, 32'h0000_DEAD);
        rd(C0_VAL, 32'h0, "R9 count write ignored");
        rd(7'h08, 32'h0, "R2 unmapped offset");
        wr(C0_DIV, 32'h0);

        // R3 hold
        wr(C0_CTRL, 32'h1);
        rd(C0_VAL, 32'h1234_5678, "R3 hold loads init");
        wr(C0_CFG, 32'h1);
        rd(C0_VAL, 32'h1234_5678, "R3 hold keeps count");
        rd(C0_VAL, 32'h1234_5678, "R3 hold keeps count later");
        rd(C0_CTRL, 32'h1, "R2 control readback");

        // R4 divider 0
        wr(C0_INIT, 32'h100);
        wr(C0_CTRL, 32'h2);
        rd(C0_VAL, 32'h100, "R4 div0 step0");
        rd(C0_VAL, 32'h101, "R4 div0 step1");
        rd(C0_VAL, 32'h102, "R4 div0 step2");

        // R4 divider 2
        wr(C0_CTRL, 32'h1);
        wr(C0_DIV, 32'h2);
        wr(C0_CTRL, 32'h2);
        rd(C0_VAL, 32'h100, "R4 div2 c1");
        rd(C0_VAL, 32'h100, "R4 div2 c2");
        rd(C0_VAL, 32'h100, "R4 div2 c3");
        rd(C0_VAL, 32'h101, "R4 div2 c4");
        rd(C0_VAL, 32'h101, "R4 div2 c5");
        rd(C0_VAL, 32'h101, "R4 div2 c6");
        rd(C0_VAL, 32'h102, "R4 div2 c7");

        // R8 enable off freezes, on resumes without reload
        wr(C0_CTRL, 32'h1);
        wr(C0_DIV, 32'h0);
        wr(C0_CTRL, 32'h2);
        wr(C0_CFG, 32'h0);
        rd(C0_VAL, 32'h101, "R8 frozen value");
        wr(C0_CFG, 32'h1);
        rd(C0_VAL, 32'h101, "R8 frozen until enabled");
        rd(C0_VAL, 32'h102, "R8 resumes from value");

        // R5 overflow after delta+1 ticks, R7 interrupt
        wr(C0_CTRL, 32'h1);
        wr(C0_CFG, 32'h3);
        wr(C0_INIT, MAXV - 32'd3);
        wr(C0_CTRL, 32'h2);
        idle(3);
        chk_irq(1'b0, "R5 no overflow before delta+1 ticks");
        idle(1);
        chk_irq(1'b1, "R5 overflow raises irq");
        rd(C0_VAL, MAXV - 32'd3, "R5 reload after wrap");
        rd(C0_VAL, MAXV - 32'd2, "R5 keeps running");
        rd(C0_STAT, 32'h1, "R5 pending set");
        // R6 clear landing on an overflow edge
        wr(C0_STAT, 32'h1);
        chk_irq(1'b1, "R6 overflow beats clear");
        wr(C0_STAT, 32'h1);
        chk_irq(1'b0, "R6 clear drops pending");
        idle(3);
        chk_irq(1'b1, "R5 periodic overflow");
        wr(C0_STAT, 32'h0);
        chk_irq(1'b1, "R6 writing 0 keeps pending");

        // R7 interrupt enable gates the output
        wr(C0_CFG, 32'h1);
        chk_irq(1'b0, "R7 irq masked");
        wr(C0_CTRL, 32'h1);
        rd(C0_STAT, 32'h1, "R7 pending still set");
        wr(C0_STAT, 32'h1);
        rd(C0_STAT, 32'h0, "R6 cleared while held");

        // R10 second channel
        wr(C1_CFG, 32'h1);
        wr(C1_INIT, 32'h50);
        wr(C1_CTRL, 32'h2);
        rd(C1_VAL, 32'h50, "R10 ch1 starts");
        rd(C1_VAL, 32'h51, "R10 ch1 counts");
        rd(C0_VAL, MAXV - 32'd3, "R10 ch0 untouched");
        wr(C1_CTRL, 32'h1);
        wr(C1_CFG, 32'h3);
        wr(C1_INIT, MAXV);
        wr(C1_CTRL, 32'h2);
        chk_irq(1'b0, "R10 ch1 at max, no irq yet");
        idle(1);
        chk_irq(1'b1, "R10 ch1 overflow irq");

        idle(3);
        check(exp_q.size() == 0, "R2 reads all answered", exp_q.size(), 32'h0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule